// File: doc/BRIEF.md
# Loadable Decade/Binary Digit Counter

This block is a four-bit synchronous up-counter. A parameter sets its modulus to ten (decade, 0 to 9) or sixteen (binary, 0 to 15). On a rising clock edge the counter does one of three things. It loads a parallel value when `load_n` is low. It increments when `load_n`, `cep` and `cet` are all high. In every other case it holds its value.

The terminal-count output `tc` is decoded from the state and gated only by `cet`. Each stage's `tc` can drive the next stage's `cet` while all stages share `cep`, so multi-digit counters need no glue logic.

A second parameter sets how the active-low `clear_n` input acts. In one style it clears the state at once, without waiting for a clock. In the other it clears the state on the next rising edge and outranks every other control. In decade mode, a loaded code from 10 to 15 steers itself back into the 0 to 9 cycle.

Top module: `sync_digit_counter`

## Requirements
- R1: With `load_n`, `cep` and `cet` all high and `q` at a legal value below the maximum, `q` becomes `q+1` on the rising edge.
- R2: With counting enabled and `q` at the maximum (9 = 4'b1001 in decade mode, 15 = 4'b1111 in binary mode), `q` becomes 0 on the rising edge.
- R3: With `load_n` low, `q` takes the value of `d` on the rising edge, whatever `cep` and `cet` are.
- R4: With `load_n` high and either `cep` or `cet` low, `q` keeps its value across the edge.
- R5: `tc` is high exactly when `cet` is high and `q` equals the maximum. It follows `cet` within the same cycle and ignores `cep`.
- R6: In decade mode with counting enabled, the illegal codes advance as 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2. Any illegal code is therefore back in 0..9 after two counting edges, and `tc` stays low in 10..15.
- R7: When `SYNC_CLEAR`=0, a low `clear_n` forces `q` to 0 without waiting for a clock and overrides all other inputs.
- R8: When `SYNC_CLEAR`=1, a low `clear_n` sets `q` to 0 on the rising edge, above `load_n`, `cep` and `cet`. Between edges it has no effect.
- R9: Three decade stages, each with `tc` feeding the next stage's `cet` and a shared `cep`, count 000 through 999 and wrap to 000. The last stage's `tc` is high only at 999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; its style is set by `SYNC_CLEAR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| cep | input | 1 | Count enable shared by all stages in a chain |
| cet | input | 1 | Count enable that also gates `tc` |
| d | input | 4 | Parallel load value |
| q | output | 4 | Counter state |
| tc | output | 1 | Terminal count |

## Verification
The assertions check on every clocked cycle that a load takes `d`, that a disabled count holds the state, and that a legal count increments or wraps. They also check that `tc` is only ever seen with `cet` high and `q` at the maximum. The bench alone shows the exact illegal-code sequence and the two-edge recovery from it. It also shows the immediate effect of the asynchronous clear, the fact that a synchronous clear does nothing between edges, and the carry ripple through a three-digit chain over a full 000 to 999 cycle. The per-state sweeps run both the decade synchronous-clear variant and the binary asynchronous-clear variant over every start value and every enable combination.

// File: rtl/sdc_pkg.sv
// Package: shared types for the digit counter.
// Assumes a fixed four-bit digit.
package sdc_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;

    // Action taken at the next rising edge (clear is handled by the register).
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } op_e;

    // Largest legal code for the selected modulus.
    function automatic digit_t max_code(input bit decade);
        return decade ? digit_t'(9) : digit_t'(15);
    endfunction
endpackage

// File: rtl/sdc_mode_sel.sv
// Module: decodes the load and the two count enables into one action.
// Assumes the controls are steady around the clock edge. Load outranks counting.
module sdc_mode_sel
    import sdc_pkg::*;
(
    input  logic load_n,
    input  logic cep,
    input  logic cet,
    output op_e  op
);
    // Priority decode: load, then count, then hold.
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (cep && cet)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/sdc_next_state.sv
// Module: next-state value for the chosen action.
// In decade mode the codes 10..15 follow a fixed steering map back into 0..9.
module sdc_next_state
    import sdc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  op_e    op,
    input  digit_t q,
    input  digit_t d,
    output digit_t nxt
);
    localparam digit_t TOP = max_code(DECADE);

    digit_t inc_val;

    // Increment with wrap at the top code and illegal-code steering.
    always_comb begin
        inc_val = digit_t'(q + 1'b1);
        if (q == TOP) begin
            inc_val = '0;
        end else if (DECADE && (q > TOP)) begin
            case (q)
                4'd11:   inc_val = 4'd6;
                4'd13:   inc_val = 4'd4;
                4'd15:   inc_val = 4'd2;
                default: inc_val = digit_t'(q + 1'b1);
            endcase
        end
    end

    // Choose the next value from the action.
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = d;
            OP_COUNT: nxt = inc_val;
            default:  nxt = q;
        endcase
    end
endmodule

// File: rtl/sdc_term_detect.sv
// Module: terminal-count decode, gated by the trickle enable.
// Purely combinational, so a chained stage sees a change on cet in the same cycle.
module sdc_term_detect
    import sdc_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  digit_t q,
    input  logic   cet,
    output logic   tc
);
    localparam digit_t TOP = max_code(DECADE);

    // Full decode of the top code.
    always_comb tc = cet && (q == TOP);
endmodule

// File: rtl/sdc_state_reg.sv
// Module: the state register. The clear style is chosen by a parameter.
// Assumes clear_n is active low in both styles.
module sdc_state_reg
    import sdc_pkg::*;
#(
    parameter bit SYNC_CLEAR = 1'b1
) (
    input  logic   clk,
    input  logic   clear_n,
    input  digit_t nxt,
    output digit_t q
);
    generate
        if (SYNC_CLEAR) begin : g_sync
            // Clear taken on the edge, ahead of every other control.
            always_ff @(posedge clk) begin
                if (!clear_n) q <= '0;
                else          q <= nxt;
            end
        end else begin : g_async
            // Clear applied at once, with no clock needed.
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) q <= '0;
                else          q <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/sync_digit_counter.sv
// Module: top of the loadable decade/binary digit counter.
// DECADE selects modulo 10 or 16. SYNC_CLEAR selects the clear style.
// Stages chain by wiring tc to the next stage's cet.
module sync_digit_counter
    import sdc_pkg::*;
#(
    parameter bit DECADE     = 1'b1,
    parameter bit SYNC_CLEAR = 1'b1
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         cep,
    input  logic         cet,
    input  logic [3:0]   d,
    output logic [3:0]   q,
    output logic         tc
);
    op_e    op;
    digit_t nxt;

    sdc_mode_sel u_mode (
        .load_n (load_n),
        .cep    (cep),
        .cet    (cet),
        .op     (op)
    );

    sdc_next_state #(.DECADE(DECADE)) u_next (
        .op  (op),
        .q   (q),
        .d   (d),
        .nxt (nxt)
    );

    sdc_state_reg #(.SYNC_CLEAR(SYNC_CLEAR)) u_reg (
        .clk     (clk),
        .clear_n (clear_n),
        .nxt     (nxt),
        .q       (q)
    );

    sdc_term_detect #(.DECADE(DECADE)) u_term (
        .q   (q),
        .cet (cet),
        .tc  (tc)
    );
endmodule

// File: rtl/sdc_chk.sv
// Checker: cycle properties of the digit counter, bound to every instance.
module sdc_chk #(
    parameter bit DECADE = 1'b1
) (
    input logic       clk,
    input logic       clear_n,
    input logic       load_n,
    input logic       cep,
    input logic       cet,
    input logic [3:0] d,
    input logic [3:0] q,
    input logic       tc
);
    localparam logic [3:0] TOP = DECADE ? 4'd9 : 4'd15;

    // R3
    load_takes_d_chk: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (q == $past(d)));

    // R4
    hold_keeps_q_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cep && cet)) |=> $stable(q));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cep && cet && (q < TOP)) |=> (q == $past(q) + 4'd1));

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cep && cet && (q == TOP)) |=> (q == 4'd0));

    // R5
    tc_needs_cet_chk: assert property (@(posedge clk) disable iff (!clear_n)
        tc |-> (cet && (q == TOP)));

    // R6
    no_tc_illegal_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (q > TOP) |-> !tc);
endmodule

bind sync_digit_counter sdc_chk #(.DECADE(DECADE)) u_chk (
    .clk     (clk),
    .clear_n (clear_n),
    .load_n  (load_n),
    .cep     (cep),
    .cet     (cet),
    .d       (d),
    .q       (q),
    .tc      (tc)
);

// File: tb/sync_digit_counter_tb.sv
module sync_digit_counter_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       clr_a_n, clr_b_n, ld_n, cep, cet;
    logic [3:0] d;
    logic [3:0] q_a, q_b;
    logic       tc_a, tc_b;

    // Decade, synchronous clear.
    sync_digit_counter #(.DECADE(1'b1), .SYNC_CLEAR(1'b1)) u_dut (
        .clk(clk), .clear_n(clr_a_n), .load_n(ld_n), .cep(cep), .cet(cet),
        .d(d), .q(q_a), .tc(tc_a));

    // Binary, asynchronous clear.
    sync_digit_counter #(.DECADE(1'b0), .SYNC_CLEAR(1'b0)) u_bin (
        .clk(clk), .clear_n(clr_b_n), .load_n(ld_n), .cep(cep), .cet(cet),
        .d(d), .q(q_b), .tc(tc_b));

    // Three-digit decade chain.
    logic       ch_clr_n, ch_ld_n, ch_cep, ch_cet;
    logic [3:0] cq0, cq1, cq2;
    logic       ctc0, ctc1, ctc2;

    sync_digit_counter u_dig0 (.clk(clk), .clear_n(ch_clr_n), .load_n(ch_ld_n),
        .cep(ch_cep), .cet(ch_cet), .d(4'd0), .q(cq0), .tc(ctc0));
    sync_digit_counter u_dig1 (.clk(clk), .clear_n(ch_clr_n), .load_n(ch_ld_n),
        .cep(ch_cep), .cet(ctc0), .d(4'd0), .q(cq1), .tc(ctc1));
    sync_digit_counter u_dig2 (.clk(clk), .clear_n(ch_clr_n), .load_n(ch_ld_n),
        .cep(ch_cep), .cet(ctc1), .d(4'd0), .q(cq2), .tc(ctc2));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected next state, worked out from the requirements.
    function automatic int ref_next(input bit dec, input int qv, input bit l_n,
                                    input bit ep, input bit et, input int dv);
        int top;
        top = dec ? 9 : 15;
        if (!l_n) return dv;
        if (!(ep && et)) return qv;
        if (qv == top) return 0;
        if (dec && qv > 9) begin
            case (qv)
                11: return 6;
                13: return 4;
                15: return 2;
                default: return qv + 1;
            endcase
        end
        return qv + 1;
    endfunction

    function automatic string tag_for(input bit dec, input int qv, input bit l_n,
                                      input bit ep, input bit et);
        if (!l_n) return "R3";
        if (!(ep && et)) return "R4";
        if (qv == (dec ? 9 : 15)) return "R2";
        if (dec && qv > 9) return "R6";
        return "R1";
    endfunction

    // One clock; inputs change and outputs are sampled 1 time unit after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clr_a_n = 1'b0; clr_b_n = 1'b0; ld_n = 1'b1; cep = 1'b1; cet = 1'b1; d = 4'd0;
        ch_clr_n = 1'b0; ch_ld_n = 1'b1; ch_cep = 1'b1; ch_cet = 1'b1;
        step(); step();
        // R8 R7: reset state
        chk("R8 reset q", int'(q_a), 0);
        chk("R7 reset q", int'(q_b), 0);
        chk("R5 reset tc", int'(tc_a), 0);
        clr_a_n = 1'b1; clr_b_n = 1'b1; ch_clr_n = 1'b1;

        // Sweep every start value and enable/load combination on both variants.
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 8; e++) begin
                bit ep, et, l_n;
                int nd;
                ld_n = 1'b0; cep = 1'b0; cet = 1'b0; d = 4'(s);
                step();
                chk("R3 load", int'(q_a), s);
                chk("R3 load", int'(q_b), s);
                ep = e[0]; et = e[1]; l_n = !e[2];
                nd = 15 - s;
                ld_n = l_n; cep = ep; cet = et; d = 4'(nd);
                #1;
                // R5: tc with cet, independent of cep
                chk("R5 tc decade", int'(tc_a), int'(et && s == 9));
                chk("R5 tc binary", int'(tc_b), int'(et && s == 15));
                step();
                chk(tag_for(1'b1, s, l_n, ep, et), int'(q_a), ref_next(1'b1, s, l_n, ep, et, nd));
                chk(tag_for(1'b0, s, l_n, ep, et), int'(q_b), ref_next(1'b0, s, l_n, ep, et, nd));
            end
        end

        // R6: recovery from every illegal loaded code within two counting edges.
        for (int s = 10; s < 16; s++) begin
            int e1, e2;
            ld_n = 1'b0; d = 4'(s); cep = 1'b1; cet = 1'b1;
            step();
            ld_n = 1'b1;
            #1;
            chk("R6 no tc illegal", int'(tc_a), 0);
            e1 = ref_next(1'b1, s, 1'b1, 1'b1, 1'b1, 0);
            e2 = ref_next(1'b1, e1, 1'b1, 1'b1, 1'b1, 0);
            step();
            chk("R6 first step", int'(q_a), e1);
            step();
            chk("R6 second step", int'(q_a), e2);
            chk("R6 legal after two", int'(q_a <= 4'd9), 1);
        end

        // R1 R2: free run through several decade and binary cycles.
        ld_n = 1'b0; d = 4'd0; step();
        ld_n = 1'b1; cep = 1'b1; cet = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            step();
            chk((k % 10 == 0) ? "R2 decade wrap" : "R1 decade count", int'(q_a), k % 10);
            chk((k % 16 == 0) ? "R2 binary wrap" : "R1 binary count", int'(q_b), k % 16);
        end

        // R8: synchronous clear waits for the edge and outranks load and count.
        ld_n = 1'b0; d = 4'd7; step();
        clr_a_n = 1'b0; ld_n = 1'b0; d = 4'd5; cep = 1'b1; cet = 1'b1;
        #2;
        chk("R8 no effect between edges", int'(q_a), 7);
        step();
        chk("R8 clear over load", int'(q_a), 0);
        ld_n = 1'b1; step();
        chk("R8 clear over count", int'(q_a), 0);
        clr_a_n = 1'b1;

        // R7: asynchronous clear acts mid-cycle, overriding load.
        ld_n = 1'b0; d = 4'd12; step();
        chk("R3 binary load", int'(q_b), 12);
        #2;
        clr_b_n = 1'b0;
        #1;
        chk("R7 immediate clear", int'(q_b), 0);
        step();
        chk("R7 clear over load", int'(q_b), 0);
        clr_b_n = 1'b1; ld_n = 1'b1;

        // R9: three-digit chain over a full cycle.
        ch_ld_n = 1'b0; step();
        ch_ld_n = 1'b1;
        chk("R9 chain start", int'(cq2) * 100 + int'(cq1) * 10 + int'(cq0), 0);
        for (int k = 1; k <= 1001; k++) begin
            int v;
            step();
            v = k % 1000;
            chk("R9 chain value", int'(cq2) * 100 + int'(cq1) * 10 + int'(cq0), v);
            chk("R9 chain tc", int'(ctc2), int'(v == 999));
        end
        // R4 R9: shared cep low freezes the whole chain.
        ch_cep = 1'b0; step();
        chk("R4 chain hold", int'(cq2) * 100 + int'(cq1) * 10 + int'(cq0), 1);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule